// File: doc/BRIEF.md
# Bus Port Halt Handshake Controller

This controller brings a bus master port to a quiet state before the logic that owns the port is put into reset. A single-cycle command starts a halt attempt. The controller raises a halt request toward the port. It then checks the port's acknowledge at a fixed polling interval. When the acknowledge is seen, it also samples the port's idle indication to confirm that the halt took effect. It then withdraws the request and reports the outcome. After that the port is treated as halted until its owner resets it.

There are three outcomes. The halt succeeds when the acknowledge arrives with idle high. The halt fails when the acknowledge arrives with idle low. The attempt times out when no acknowledge is seen within the polling budget. The polling interval is a whole number of clock cycles, `CLKS_PER_POLL`. The budget is a number of polls, `MAX_POLLS`. At the default values and a 125 MHz clock this gives polls every 50 µs and a limit of 100 ms. The acknowledge and idle inputs may come from another clock domain, so both pass through a two-flop synchroniser.

Top module: `port_halt_ctrl`

## Requirements
- R1: After reset, `halt_req`, `done`, `halted_ok`, `halt_failed` and `timed_out` are all 0.
- R2: A `halt_cmd` sampled high while the controller is not busy makes `halt_req` go high on the next cycle. `halt_req` stays high without a break until the cycle in which `done` pulses.
- R3: The synchronised acknowledge is examined only at polls. Poll n falls at the clock edge n×`CLKS_PER_POLL` counted from the edge that accepted the command. The outcome becomes visible right after the first poll that finds the acknowledge high.
- R4: A change on `port_ack` or `port_idle` driven just after edge k is first visible to a poll at edge k+3. This follows from two synchroniser stages plus the sampling edge.
- R5: If a poll finds the acknowledge high and idle high, `halted_ok` is set.
- R6: If a poll finds the acknowledge high and idle low, `halt_failed` is set.
- R7: If `MAX_POLLS` polls pass without an acknowledge, `timed_out` is set at edge `MAX_POLLS`×`CLKS_PER_POLL`. An acknowledge seen at the last poll still counts as an acknowledge.
- R8: `done` is high for exactly one cycle. In that cycle `halt_req` is already low, and exactly one of the three status flags is set.
- R9: The status flags keep their value after `done` until the next accepted command, which clears all three on the cycle that `halt_req` rises.
- R10: A `halt_cmd` that arrives while a halt attempt is running is ignored. It does not restart polling, does not shift when the outcome arrives, and does not produce a second `done`.
- R11: An acknowledge pulse that rises and falls entirely between two polls is not seen and has no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_cmd | input | 1 | Start a halt attempt (sampled when idle) |
| port_ack | input | 1 | Halt acknowledge from the port (asynchronous) |
| port_idle | input | 1 | Port idle indication (asynchronous) |
| halt_req | output | 1 | Halt request toward the port |
| done | output | 1 | One-cycle pulse with the final outcome |
| halted_ok | output | 1 | Halt acknowledged and port idle |
| halt_failed | output | 1 | Halt acknowledged but port not idle |
| timed_out | output | 1 | No acknowledge within the poll budget |

## Verification
Two timing corners are hard to reach from the ports. One is an acknowledge that lands exactly on a poll boundary after synchroniser delay. The other is an acknowledge that shows up only at the final poll, one step before a timeout. The bench schedules each acknowledge edge relative to the command-accepting edge, using a small prescaler and poll budget. It places the edges one cycle either side of those boundaries. It also drives a narrow acknowledge pulse that lies between two polls, and it sends repeat commands in the middle of an attempt. The expected outcome and latency come from the poll arithmetic.

// File: rtl/halt_pkg.sv
// Package: shared state type for the port halt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package halt_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } halt_state_e;
endpackage

// File: rtl/halt_sync.sv
// Module: halt_sync
// Two-flop synchroniser for a vector of independent level signals.
// Assumes: each bit is a slow level; no bus coherency across bits needed.
module halt_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    // Capture the asynchronous inputs through two flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;

    // Cycles since reset release, saturating; used only by the check below.
    logic [1:0] warm;
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    assert_two_stage_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm >= 2'd2) |-> (q == $past(d, 2)));
endmodule

// File: rtl/halt_poll_timer.sv
// Module: halt_poll_timer
// Prescaler that produces a poll strobe every CLKS_PER_POLL cycles while
// running, plus a count of polls so far and a flag for the final poll.
// Assumes: start and run are never high together (start comes from idle).
module halt_poll_timer #(
    parameter int CLKS_PER_POLL = 6250,
    parameter int MAX_POLLS     = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic run,
    output logic poll,
    output logic last_poll
);
    localparam int CNT_W  = $clog2(CLKS_PER_POLL + 1);
    localparam int POLL_W = $clog2(MAX_POLLS + 1);
    localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(CLKS_PER_POLL - 1);
    localparam logic [POLL_W-1:0] POLL_TOP = POLL_W'(MAX_POLLS - 1);

    logic [CNT_W-1:0]  cyc_cnt;
    logic [POLL_W-1:0] poll_cnt;

    assign poll      = run && (cyc_cnt == CNT_TOP);
    assign last_poll = (poll_cnt == POLL_TOP);

    // Cycle prescaler: restarts on a new attempt, wraps at each poll.
    always_ff @(posedge clk) begin
        if (!rst_n)     cyc_cnt <= '0;
        else if (start) cyc_cnt <= '0;
        else if (poll)  cyc_cnt <= '0;
        else if (run)   cyc_cnt <= cyc_cnt + 1'b1;
    end

    // Poll counter: number of polls already taken in this attempt.
    always_ff @(posedge clk) begin
        if (!rst_n)     poll_cnt <= '0;
        else if (start) poll_cnt <= '0;
        else if (poll && !last_poll) poll_cnt <= poll_cnt + 1'b1;
    end

    assert_poll_budget_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (poll_cnt < POLL_W'(MAX_POLLS)));
    assert_poll_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        poll |=> !poll);
endmodule

// File: rtl/halt_seq.sv
// Module: halt_seq
// Sequencer: accepts a command, holds the halt request while polling, and
// turns the synchronised acknowledge/idle seen at a poll into one outcome.
// Assumes: ack_s/idle_s are already synchronised to clk.
module halt_seq
    import halt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd,
    input  logic ack_s,
    input  logic idle_s,
    input  logic poll,
    input  logic last_poll,
    output logic start,
    output logic run,
    output logic req,
    output logic done,
    output logic ok,
    output logic fail,
    output logic tmo
);
    halt_state_e state;
    logic        finish;

    assign start  = (state == ST_IDLE) && cmd;
    assign run    = (state == ST_WAIT);
    assign finish = run && poll && (ack_s || last_poll);

    // State register: idle until a command, wait until an outcome.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (start)  state <= ST_WAIT;
        else if (finish) state <= ST_IDLE;
    end

    // Halt request toward the port and the one-cycle completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= finish;
            if (start)       req <= 1'b1;
            else if (finish) req <= 1'b0;
        end
    end

    // Outcome flags: cleared on acceptance, set once at the final poll.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok   <= 1'b0;
            fail <= 1'b0;
            tmo  <= 1'b0;
        end else if (start) begin
            ok   <= 1'b0;
            fail <= 1'b0;
            tmo  <= 1'b0;
        end else if (finish) begin
            ok   <= ack_s && idle_s;
            fail <= ack_s && !idle_s;
            tmo  <= !ack_s;
        end
    end

    assert_done_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot({ok, fail, tmo}));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_req_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!req && $past(req)));
    assert_done_on_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(poll));
    assert_req_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !poll) |=> req);
    assert_flags_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cmd) |=> $stable({ok, fail, tmo}));
    assert_busy_cmd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cmd && !poll) |=> run);
endmodule

// File: rtl/port_halt_ctrl.sv
// Module: port_halt_ctrl (top)
// Halt handshake controller for a bus master port: request, poll the
// acknowledge on a prescaled interval, confirm idle, release, report.
// Assumes: port_ack/port_idle may be asynchronous; halt_cmd is synchronous.
module port_halt_ctrl #(
    parameter int CLKS_PER_POLL = 6250,
    parameter int MAX_POLLS     = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_cmd,
    input  logic port_ack,
    input  logic port_idle,
    output logic halt_req,
    output logic done,
    output logic halted_ok,
    output logic halt_failed,
    output logic timed_out
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] sync_q;
    logic start, run, poll, last_poll;

    halt_sync #(.W(SYNC_W)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({port_idle, port_ack}),
        .q     (sync_q)
    );

    halt_poll_timer #(
        .CLKS_PER_POLL (CLKS_PER_POLL),
        .MAX_POLLS     (MAX_POLLS)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (run),
        .poll      (poll),
        .last_poll (last_poll)
    );

    halt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd       (halt_cmd),
        .ack_s     (sync_q[0]),
        .idle_s    (sync_q[1]),
        .poll      (poll),
        .last_poll (last_poll),
        .start     (start),
        .run       (run),
        .req       (halt_req),
        .done      (done),
        .ok        (halted_ok),
        .fail      (halt_failed),
        .tmo       (timed_out)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !halt_req && !done && !halted_ok && !halt_failed && !timed_out);
endmodule

// File: tb/port_halt_ctrl_test.sv
// Scoreboard bench: the driver pushes expected outcome and latency, and the
// monitor times each attempt from the rise of halt_req and compares.
module port_halt_ctrl_test;
    localparam int P   = 4;
    localparam int MAX = 5;
    localparam int NEVER = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt_cmd = 1'b0;
    logic port_ack = 1'b0;
    logic port_idle = 1'b0;
    logic halt_req, done, halted_ok, halt_failed, timed_out;

    int checks = 0;
    int fails  = 0;
    int exp_code_q[$];
    int exp_lat_q[$];
    bit finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    port_halt_ctrl #(.CLKS_PER_POLL(P), .MAX_POLLS(MAX)) uut (
        .clk(clk), .rst_n(rst_n), .halt_cmd(halt_cmd),
        .port_ack(port_ack), .port_idle(port_idle),
        .halt_req(halt_req), .done(done), .halted_ok(halted_ok),
        .halt_failed(halt_failed), .timed_out(timed_out)
    );

    task automatic check(input bit cond, input string req, input int act, input int expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int flags_code();
        return {29'd0, timed_out, halt_failed, halted_ok};
    endfunction

    // Expected outcome: 1=ok, 2=fail, 4=timeout; poll n sees ack when on+3<=nP<=off+2.
    task automatic predict(input bit idle, input int on, input int off,
                           output int code, output int lat);
        code = 4;
        lat  = MAX * P;
        for (int n = 1; n <= MAX; n++) begin
            if ((on + 3 <= n * P) && (n * P <= off + 2)) begin
                code = idle ? 1 : 2;
                lat  = n * P;
                break;
            end
        end
    endtask

    // Driver: one attempt with ack high after edge 'on' until edge 'off'.
    task automatic run_case(input bit idle, input int on, input int off,
                            input bit extra_cmd, input string tag);
        int code, lat;
        int prev;
        predict(idle, on, off, code, lat);
        exp_code_q.push_back(code);
        exp_lat_q.push_back(lat);
        @(negedge clk);
        port_idle = idle;
        port_ack  = 1'b0;
        repeat (4) @(negedge clk);
        prev = flags_code();
        halt_cmd = 1'b1;
        @(posedge clk);
        @(negedge clk);
        halt_cmd = 1'b0;
        // R9: flags cleared on acceptance.
        check(flags_code() == 0, {"R9 clear ", tag}, flags_code(), 0);
        for (int k = 0; k <= lat + 1; k++) begin
            port_ack = (k >= on) && (k < off) && (k < lat);
            if (extra_cmd) halt_cmd = (k == 2) || (k == 6);
            if (k > 0) begin end
            @(posedge clk);
            @(negedge clk);
        end
        halt_cmd = 1'b0;
        port_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R9: flags held after done.
        check(flags_code() == code, {"R9 held ", tag}, flags_code(), code);
        check(!halt_req, {"R8 req low after ", tag}, halt_req, 0);
        if (prev < 0) $display("unreachable");
    endtask

    // Monitor: measure latency from halt_req rise to done, compare with queue.
    initial begin
        bit active = 1'b0;
        bit prev_done = 1'b0;
        int lat = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (prev_done) check(!done, "R8 done one cycle", done, 0);
                if (!active && halt_req) begin
                    active = 1'b1;
                    lat = 0;
                end else if (active) begin
                    lat++;
                    if (done) begin
                        active = 1'b0;
                        if (exp_code_q.size() == 0) begin
                            check(1'b0, "R10 unexpected done", 1, 0);
                        end else begin
                            int ec, el;
                            ec = exp_code_q.pop_front();
                            el = exp_lat_q.pop_front();
                            check(flags_code() == ec, "R5 R6 R7 outcome", flags_code(), ec);
                            check(lat == el, "R3 R4 latency", lat, el);
                            check(!halt_req, "R8 req low at done", halt_req, 0);
                        end
                    end else if (!halt_req) begin
                        check(1'b0, "R2 req dropped early", 0, 1);
                        active = 1'b0;
                    end
                end else if (done) begin
                    check(1'b0, "R10 done while not active", 1, 0);
                end
                prev_done = done;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check({halt_req, done, halted_ok, halt_failed, timed_out} == 5'b0,
              "R1 reset", {halt_req, done, halted_ok, halt_failed, timed_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!halt_req && !done, "R1 after release", halt_req, 0);

        run_case(1'b1, 0,  NEVER, 1'b0, "R5 fast ok");          // lat 4
        run_case(1'b1, 1,  NEVER, 1'b0, "R4 boundary hit");     // lat 4
        run_case(1'b1, 2,  NEVER, 1'b0, "R4 boundary miss");    // lat 8
        run_case(1'b0, 5,  NEVER, 1'b0, "R6 not idle");         // fail, lat 8
        run_case(1'b1, NEVER, NEVER, 1'b0, "R7 no ack");        // timeout, lat 20
        run_case(1'b1, 17, NEVER, 1'b0, "R7 last poll ack");    // ok, lat 20
        run_case(1'b1, 18, NEVER, 1'b0, "R7 just too late");    // timeout, lat 20
        run_case(1'b0, 6,  NEVER, 1'b1, "R10 busy cmd");        // fail, lat 12
        run_case(1'b1, 4,  5,     1'b0, "R11 short pulse");     // timeout, lat 20

        repeat (5) @(negedge clk);
        check(exp_code_q.size() == 0, "R10 all outcomes seen", exp_code_q.size(), 0);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule